// File: doc/BRIEF.md
# Link-Access Frame Transmit Encapsulator

This block turns an Ethernet packet, delivered as a stream of octets with valid, ready and last signals, into a link-access frame on an octet-wide output. Each frame opens with a flag octet (0x7E). Next come a configurable address octet, a configurable control octet, a configurable two-octet protocol identifier, the packet payload, and a 32-bit frame check sequence. A closing flag ends the frame. The output produces exactly one octet per clock. When no packet is waiting, the output repeats the flag octet.

Every octet between the opening and closing flags passes through octet transparency. An octet equal to the flag or to the escape octet (0x7D) becomes a two-octet pair: the escape octet, then the original octet XOR 0x20. The check sequence covers the header fields and the payload before escaping. The source may pause in the middle of a packet. During a pause, the block fills the gap with the rate-adaptation pair 0x7D, 0xDD, which the receiver discards. The configuration inputs are expected to change only while the block is idle.

Top module: `laps_tx_encap`

## Requirements
- R1: After reset, and whenever no packet is pending, the output carries 0x7E on every cycle and `in_ready` stays low.
- R2: A frame starts with one 0x7E flag, followed by `cfg_addr` and then `cfg_ctrl`.
- R3: The protocol identifier follows the control octet as two octets: `cfg_sapi[15:8]` first, then `cfg_sapi[7:0]`.
- R4: Payload octets are sent in arrival order. An octet of value 0x7E is sent as the pair 0x7D, 0x5E.
- R5: An octet of value 0x7D anywhere between the flags is sent as the pair 0x7D, 0x5D.
- R6: In the cycle after a payload octet that needs escaping is accepted, `in_ready` is low.
- R7: The check sequence follows the payload. It is the complement of a reflected CRC-32 (polynomial 0xEDB88320, register preset to all ones) computed over address, control, identifier and payload before escaping. It is sent least significant octet first, and its octets are escaped like any other.
- R8: A single 0x7E closes each frame. A packet that is already waiting starts its frame with a fresh opening flag immediately after that closing flag.
- R9: If `in_valid` is low while `in_ready` is high in mid-packet, the block sends 0x7D, 0xDD. No payload octet is consumed and the check sequence is unchanged.
- R10: Address, control and identifier octets equal to 0x7E or 0x7D are escaped as in R4 and R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_addr | input | 8 | Address octet placed after the opening flag |
| cfg_ctrl | input | 8 | Control octet placed after the address |
| cfg_sapi | input | 16 | Protocol identifier, high octet sent first |
| in_data | input | 8 | Payload octet |
| in_valid | input | 1 | Payload octet is present |
| in_last | input | 1 | Payload octet is the final one of the packet |
| in_ready | output | 1 | Block accepts the payload octet this cycle |
| out_data | output | 8 | Encapsulated octet stream, one octet per cycle |

## Verification
The bench builds the block with its default parameters: a two-octet identifier, the reflected CRC-32 polynomial, and the standard flag, escape and rate-adaptation codes. With these values, every escape case is reachable with short packets. This includes escaped header fields, adjacent escaped payload octets, a one-octet payload that itself needs escaping, a pause in mid-payload, and a second packet that is already waiting when the first frame closes. The expected streams come from a bit-serial CRC model in the bench and from the escaping rules alone.

// File: rtl/laps_tx_pkg.sv
package laps_tx_pkg;

    localparam int OCT_W = 8;
    localparam int CRC_W = 32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_PAY,
        ST_FCS,
        ST_CLOSE
    } laps_st_e;

endpackage

// File: rtl/laps_crc32_byte.sv
module laps_crc32_byte #(
    parameter int                CRC_W = 32,
    parameter int                OCT_W = 8,
    parameter logic [CRC_W-1:0]  POLY  = 32'hEDB88320
) (
    input  logic [CRC_W-1:0] crc_in,
    input  logic [OCT_W-1:0] oct_in,
    output logic [CRC_W-1:0] crc_out
);

    // Reflected, bit-serial update unrolled over one octet, LSB first.
    always_comb begin
        logic [CRC_W-1:0] c;
        logic             fb;
        c = crc_in;
        for (int b = 0; b < OCT_W; b++) begin
            fb = c[0] ^ oct_in[b];
            c  = c >> 1;
            if (fb) begin
                c = c ^ POLY;
            end
        end
        crc_out = c;
    end

endmodule

// File: rtl/laps_octet_escape.sv
module laps_octet_escape #(
    parameter int               OCT_W     = 8,
    parameter logic [OCT_W-1:0] FLAG      = 8'h7E,
    parameter logic [OCT_W-1:0] ESC       = 8'h7D,
    parameter logic [OCT_W-1:0] ESC_XOR   = 8'h20,
    parameter logic [OCT_W-1:0] FILL_CODE = 8'hDD
) (
    input  logic [OCT_W-1:0] raw_oct,
    input  logic             fill_req,
    output logic [OCT_W-1:0] first_oct,
    output logic             pair,
    output logic [OCT_W-1:0] second_oct
);

    always_comb begin
        first_oct  = raw_oct;
        pair       = 1'b0;
        second_oct = raw_oct ^ ESC_XOR;
        if (fill_req) begin
            first_oct  = ESC;
            pair       = 1'b1;
            second_oct = FILL_CODE;
        end else if ((raw_oct == FLAG) || (raw_oct == ESC)) begin
            first_oct = ESC;
            pair      = 1'b1;
        end
    end

endmodule

// File: rtl/laps_hdr_select.sv
module laps_hdr_select #(
    parameter int OCT_W       = 8,
    parameter int SAPI_OCTETS = 2,
    parameter int IDX_W       = 2
) (
    input  logic [OCT_W-1:0]             addr,
    input  logic [OCT_W-1:0]             ctrl,
    input  logic [SAPI_OCTETS*OCT_W-1:0] sapi,
    input  logic [IDX_W-1:0]             idx,
    output logic [OCT_W-1:0]             hdr_oct,
    output logic                         hdr_last
);

    localparam int HDR_N = 2 + SAPI_OCTETS;

    logic [OCT_W-1:0] tbl [HDR_N];

    assign tbl[0] = addr;
    assign tbl[1] = ctrl;

    // Identifier octets: most significant first.
    generate
        for (genvar g = 0; g < SAPI_OCTETS; g++) begin : g_sapi
            assign tbl[2+g] = sapi[(SAPI_OCTETS-1-g)*OCT_W +: OCT_W];
        end
    endgenerate

    always_comb begin
        hdr_oct = '0;
        for (int k = 0; k < HDR_N; k++) begin
            if (idx == IDX_W'(k)) begin
                hdr_oct = tbl[k];
            end
        end
    end

    assign hdr_last = (idx == IDX_W'(HDR_N - 1));

endmodule

// File: rtl/laps_tx_encap.sv
module laps_tx_encap
    import laps_tx_pkg::*;
#(
    parameter int                SAPI_OCTETS = 2,
    parameter logic [CRC_W-1:0]  CRC_POLY    = 32'hEDB88320,
    parameter logic [CRC_W-1:0]  CRC_INIT    = 32'hFFFF_FFFF,
    parameter logic [OCT_W-1:0]  FLAG        = 8'h7E,
    parameter logic [OCT_W-1:0]  ESC         = 8'h7D,
    parameter logic [OCT_W-1:0]  ESC_XOR     = 8'h20,
    parameter logic [OCT_W-1:0]  FILL_CODE   = 8'hDD
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [OCT_W-1:0]             cfg_addr,
    input  logic [OCT_W-1:0]             cfg_ctrl,
    input  logic [SAPI_OCTETS*OCT_W-1:0] cfg_sapi,
    input  logic [OCT_W-1:0]             in_data,
    input  logic                         in_valid,
    input  logic                         in_last,
    output logic                         in_ready,
    output logic [OCT_W-1:0]             out_data
);

    localparam int HDR_N  = 2 + SAPI_OCTETS;
    localparam int FCS_N  = CRC_W / OCT_W;
    localparam int MAX_N  = (HDR_N > FCS_N) ? HDR_N : FCS_N;
    localparam int IDX_W  = (MAX_N > 1) ? $clog2(MAX_N) : 1;

    typedef struct packed {
        laps_st_e         st;
        logic [IDX_W-1:0] idx;
        logic [CRC_W-1:0] crc;
        logic             esc_pend;
        logic [OCT_W-1:0] esc_oct;
        logic [OCT_W-1:0] out;
    } enc_state_t;

    enc_state_t q, d;

    logic [OCT_W-1:0] hdr_oct;
    logic             hdr_last;
    logic [OCT_W-1:0] raw_oct;
    logic             fill_req;
    logic             emit;
    logic [CRC_W-1:0] crc_next;
    logic [OCT_W-1:0] esc_first;
    logic             esc_pair;
    logic [OCT_W-1:0] esc_second;

    laps_hdr_select #(
        .OCT_W      (OCT_W),
        .SAPI_OCTETS(SAPI_OCTETS),
        .IDX_W      (IDX_W)
    ) u_hdr (
        .addr    (cfg_addr),
        .ctrl    (cfg_ctrl),
        .sapi    (cfg_sapi),
        .idx     (q.idx),
        .hdr_oct (hdr_oct),
        .hdr_last(hdr_last)
    );

    laps_crc32_byte #(
        .CRC_W(CRC_W),
        .OCT_W(OCT_W),
        .POLY (CRC_POLY)
    ) u_crc (
        .crc_in (q.crc),
        .oct_in (raw_oct),
        .crc_out(crc_next)
    );

    laps_octet_escape #(
        .OCT_W    (OCT_W),
        .FLAG     (FLAG),
        .ESC      (ESC),
        .ESC_XOR  (ESC_XOR),
        .FILL_CODE(FILL_CODE)
    ) u_esc (
        .raw_oct   (raw_oct),
        .fill_req  (fill_req),
        .first_oct (esc_first),
        .pair      (esc_pair),
        .second_oct(esc_second)
    );

    // Octet source selection for the current cycle.
    always_comb begin
        raw_oct  = '0;
        fill_req = 1'b0;
        emit     = 1'b0;
        if (!q.esc_pend) begin
            unique case (q.st)
                ST_HDR: begin
                    raw_oct = hdr_oct;
                    emit    = 1'b1;
                end
                ST_PAY: begin
                    emit = 1'b1;
                    if (in_valid) begin
                        raw_oct = in_data;
                    end else begin
                        fill_req = 1'b1;
                    end
                end
                ST_FCS: begin
                    raw_oct = ~q.crc[q.idx*OCT_W +: OCT_W];
                    emit    = 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Next-state computation.
    always_comb begin
        d = q;
        if (q.esc_pend) begin
            d.out      = q.esc_oct;
            d.esc_pend = 1'b0;
        end else begin
            unique case (q.st)
                ST_IDLE: begin
                    d.out = FLAG;
                    if (in_valid) begin
                        d.st  = ST_HDR;
                        d.idx = '0;
                        d.crc = CRC_INIT;
                    end
                end
                ST_HDR: begin
                    d.crc = crc_next;
                    if (hdr_last) begin
                        d.st  = ST_PAY;
                        d.idx = '0;
                    end else begin
                        d.idx = q.idx + 1'b1;
                    end
                end
                ST_PAY: begin
                    if (in_valid) begin
                        d.crc = crc_next;
                        if (in_last) begin
                            d.st  = ST_FCS;
                            d.idx = '0;
                        end
                    end
                end
                ST_FCS: begin
                    if (q.idx == IDX_W'(FCS_N - 1)) begin
                        d.st  = ST_CLOSE;
                        d.idx = '0;
                    end else begin
                        d.idx = q.idx + 1'b1;
                    end
                end
                ST_CLOSE: begin
                    d.out = FLAG;
                    d.st  = ST_IDLE;
                end
                default: begin
                    d.out = FLAG;
                    d.st  = ST_IDLE;
                end
            endcase
            if (emit) begin
                d.out      = esc_first;
                d.esc_pend = esc_pair;
                d.esc_oct  = esc_second;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st       <= ST_IDLE;
            q.idx      <= '0;
            q.crc      <= CRC_INIT;
            q.esc_pend <= 1'b0;
            q.esc_oct  <= '0;
            q.out      <= FLAG;
        end else begin
            q <= d;
        end
    end

    assign in_ready = (q.st == ST_PAY) && !q.esc_pend;
    assign out_data = q.out;

    AST_IDLE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE && !q.esc_pend) |=> (out_data == FLAG)) else $error("idle fill"); // R1
    AST_ACCEPT_NOT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (out_data != FLAG)) else $error("flag leak"); // R4
    AST_ESC_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
        (out_data == ESC) |=> ((out_data == (FLAG ^ ESC_XOR)) || (out_data == (ESC ^ ESC_XOR))
                               || (out_data == FILL_CODE))) else $error("bad pair"); // R5
    AST_READY_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && ((in_data == FLAG) || (in_data == ESC))) |=> !in_ready)
        else $error("ready gap"); // R6
    AST_UNDERRUN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid) |=> (out_data == ESC)) else $error("underrun fill"); // R9

endmodule

// File: tb/tb_laps_tx_encap.sv
`timescale 1ns/100ps
module tb_laps_tx_encap;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_addr = 8'h04;
    logic [7:0]  cfg_ctrl = 8'h03;
    logic [15:0] cfg_sapi = 16'hFE01;
    logic [7:0]  in_data = 8'h00;
    logic        in_valid = 1'b0;
    logic        in_last = 1'b0;
    logic        in_ready;
    logic [7:0]  out_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    bit rec = 1'b0;
    logic [7:0] cap[$];
    logic [7:0] exp_q[$];
    int cap_pos = 0;

    always #2.5 clk = ~clk;

    laps_tx_encap dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_addr(cfg_addr), .cfg_ctrl(cfg_ctrl), .cfg_sapi(cfg_sapi),
        .in_data(in_data), .in_valid(in_valid), .in_last(in_last),
        .in_ready(in_ready), .out_data(out_data)
    );

    always @(negedge clk) if (rec) cap.push_back(out_data);

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] o);
        logic [31:0] r = c;
        for (int i = 0; i < 8; i++) begin
            if ((r[0] ^ o[i]) == 1'b1) r = (r >> 1) ^ 32'hEDB88320;
            else r = r >> 1;
        end
        return r;
    endfunction

    task automatic push_esc(input logic [7:0] o);
        if (o == 8'h7E || o == 8'h7D) begin
            exp_q.push_back(8'h7D);
            exp_q.push_back(o ^ 8'h20);
        end else exp_q.push_back(o);
    endtask

    // Expected escaped body plus closing flag; optional 7D,DD after payload index stall_after.
    task automatic build_exp(input logic [7:0] pl[$], input int stall_after);
        logic [7:0]  raw[$];
        logic [31:0] c = 32'hFFFF_FFFF;
        exp_q.delete();
        raw.push_back(cfg_addr);
        raw.push_back(cfg_ctrl);
        raw.push_back(cfg_sapi[15:8]);
        raw.push_back(cfg_sapi[7:0]);
        foreach (raw[i]) begin
            c = crc_step(c, raw[i]);
            push_esc(raw[i]);
        end
        foreach (pl[i]) begin
            c = crc_step(c, pl[i]);
            push_esc(pl[i]);
            if (i == stall_after) begin
                exp_q.push_back(8'h7D);
                exp_q.push_back(8'hDD);
            end
        end
        c = ~c;
        for (int k = 0; k < 4; k++) push_esc(c[8*k +: 8]);
        exp_q.push_back(8'h7E);
    endtask

    task automatic check_frame(input string tag);
        int p = cap_pos;
        int bad = -1;
        while (p < cap.size() && cap[p] == 8'h7E) p++;
        if (p == cap_pos || p + exp_q.size() > cap.size()) begin
            check(1'b0, {tag, " frame position"}, p, cap_pos);
        end else begin
            foreach (exp_q[i]) if (bad < 0 && cap[p+i] !== exp_q[i]) bad = i;
            if (bad >= 0) check(1'b0, {tag, " frame octet"}, cap[p+bad], exp_q[bad]);
            else check(1'b1, tag, 0, 0);
        end
        cap_pos = p + exp_q.size();
    endtask

    task automatic start_rec();
        cap.delete();
        cap_pos = 0;
        rec = 1'b1;
    endtask

    task automatic stop_rec();
        repeat (12) @(negedge clk);
        rec = 1'b0;
    endtask

    task automatic drive_byte(input logic [7:0] b, input bit last);
        in_valid = 1'b1;
        in_data  = b;
        in_last  = last;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic send_pkt(input logic [7:0] pl[$], input int stall_after);
        foreach (pl[i]) begin
            drive_byte(pl[i], i == pl.size() - 1);
            if (pl[i] == 8'h7E || pl[i] == 8'h7D) begin
                #1;
                check(in_ready == 1'b0, "R6 ready gap after escape", in_ready, 0);
            end
            if (i == stall_after) begin
                in_valid = 1'b0;
                @(negedge clk);
            end
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(out_data == 8'h7E, "R1 reset output", out_data, 8'h7E);
        check(in_ready == 1'b0, "R1 reset ready", in_ready, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_idle();
        bit rdy_seen = 1'b0;
        bit bad = 1'b0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (out_data != 8'h7E) bad = 1'b1;
            if (in_ready) rdy_seen = 1'b1;
        end
        check(!bad, "R1 idle fill", 0, 8'h7E);
        check(!rdy_seen, "R1 idle ready low", rdy_seen, 0);
    endtask

    task automatic t_basic();
        logic [7:0] pl[$];
        for (int i = 0; i < 16; i++) pl.push_back(8'h10 + 8'(i));
        start_rec();
        send_pkt(pl, -1);
        stop_rec();
        build_exp(pl, -1);
        check_frame("R2/R3/R4/R7/R8 basic");
    endtask

    task automatic t_escape();
        logic [7:0] pl[$] = '{8'h01, 8'h7E, 8'h7D, 8'h5E, 8'h7D, 8'h7E, 8'h00};
        start_rec();
        send_pkt(pl, -1);
        stop_rec();
        build_exp(pl, -1);
        check_frame("R4/R5/R7 escaped payload");
    endtask

    task automatic t_hdr_esc();
        logic [7:0] pl[$] = '{8'hAA, 8'h55, 8'h33};
        cfg_addr = 8'h7E;
        cfg_ctrl = 8'h7D;
        cfg_sapi = 16'h7D7E;
        start_rec();
        send_pkt(pl, -1);
        stop_rec();
        build_exp(pl, -1);
        check_frame("R10/R3/R7 escaped header");
        cfg_addr = 8'h04;
        cfg_ctrl = 8'h03;
        cfg_sapi = 16'hFE01;
    endtask

    task automatic t_underrun();
        logic [7:0] pl[$] = '{8'h21, 8'h22, 8'h23, 8'h24, 8'h25, 8'h26};
        start_rec();
        send_pkt(pl, 2);
        stop_rec();
        build_exp(pl, 2);
        check_frame("R9 rate adaptation fill");
    endtask

    task automatic t_single();
        logic [7:0] pl[$] = '{8'h7E};
        start_rec();
        send_pkt(pl, -1);
        stop_rec();
        build_exp(pl, -1);
        check_frame("R4/R7 single escaped octet");
    endtask

    task automatic t_b2b();
        logic [7:0] p1[$] = '{8'h41, 8'h42, 8'h43, 8'h44};
        logic [7:0] p2[$] = '{8'h7D, 8'h51, 8'h52};
        start_rec();
        send_pkt(p1, -1);
        send_pkt(p2, -1);
        stop_rec();
        build_exp(p1, -1);
        check_frame("R8 first of back-to-back");
        build_exp(p2, -1);
        check_frame("R8 second of back-to-back");
        check(cap[cap.size()-1] == 8'h7E, "R1 fill after frames", cap[cap.size()-1], 8'h7E);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_idle();
        t_basic();
        t_escape();
        t_hdr_esc();
        t_underrun();
        t_single();
        t_b2b();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule